// File: doc/BRIEF.md
# Flash Read Accelerator with Line and Speculation Buffers

This block sits between a 32-bit system bus slave port and a wide, slow, read-only nonvolatile memory array. A master reads bytes, halfwords or words. The block fetches whole memory lines from the array and extracts the requested lanes from them. It keeps two line-sized buffers. The line buffer holds the most recently used line. The speculation buffer holds the line that follows it, which the block fetches in the background. A read that hits either buffer completes without touching the array. A read that misses both stalls the bus until the array returns the line.

The array port uses a one-cycle request strobe that carries a line address. The array answers with a data-valid strobe a fixed number of cycles later and never has more than one request outstanding. A bus write, a misaligned access or an unsupported size is answered with a bus error and goes nowhere near the array. A clear input drops the contents of both buffers.

The controller is one state machine with four states. `ST_IDLE` accepts a request and resolves errors and buffer hits at once. It moves to `ST_RESP` on an error or a hit, to `ST_WAIT_PF` on a miss while a prefetch is still in flight, and to `ST_FILL` on a miss while the array is idle. `ST_WAIT_PF` waits for the prefetch to return, then issues the demand fetch and moves to `ST_FILL`. `ST_FILL` waits for the demand line, loads it into the line buffer, starts the next-line prefetch and moves to `ST_RESP`. `ST_RESP` presents the response for one cycle and returns to `ST_IDLE`.

Top module: `flash_accel`

## Requirements
- R1: After reset both buffers are empty, and `bus_ready`, `bus_err` and `mem_req` are low until a request arrives.
- R2: `bus_size` codes are 0 = byte, 1 = halfword, 2 = word. Read data is little-endian: the byte at the lowest address appears on `bus_rdata[7:0]`, and a byte or halfword result is zero-extended to 32 bits.
- R3: A halfword at an odd address, a word whose address bits [1:0] are not zero, or `bus_size` = 3 is answered one cycle later with `bus_ready` and `bus_err` high and `bus_rdata` zero.
- R4: A write is answered one cycle later with a bus error and issues no array request. A read of the buffered line afterwards still hits with unchanged data.
- R5: A read that hits the line buffer raises `bus_ready` in the cycle after the request and issues no array request.
- R6: A read that misses both buffers while the array is idle issues exactly one `mem_req` carrying its line address. `bus_ready` rises in the cycle after `mem_valid` returns.
- R7: In the cycle in which a demand-filled read is answered, the block issues a prefetch of the next line address. The prefetched line fills the speculation buffer.
- R8: A read that hits the speculation buffer is answered in the cycle after the request. That line becomes the line buffer's content, and a prefetch of the following line is issued at the same time.
- R9: A miss that arrives while a prefetch is outstanding waits for the prefetch to return, then issues its own demand fetch and returns correct data.
- R10: A one-cycle `invalidate` pulse empties both buffers. A prefetch that is in flight at the time of the pulse is discarded when it returns.
- R11: `bus_ready` is never high in two consecutive cycles, and no array request is issued while another is outstanding.
- R12: The line width is a parameter: 128 bits (16-byte lines) by default, or 64 bits (8-byte lines). Addresses that differ only above the line offset occupy different lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| invalidate | input | 1 | Clears both buffers |
| bus_req | input | 1 | Request, held with its address until `bus_ready` |
| bus_write | input | 1 | Request is a write (always rejected) |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_ready | output | 1 | One-cycle response strobe |
| bus_err | output | 1 | Error response, valid with `bus_ready` |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| mem_req | output | 1 | One-cycle array request strobe |
| mem_line_addr | output | ADDR_W-log2(LINE_W/8) | Line address of the array request |
| mem_valid | input | 1 | Array data-valid strobe |
| mem_rdata | input | LINE_W | Array line data |

## Verification
The bench builds the block with `LINE_W` = 64, `ADDR_W` = 10 and `ARRAY_LAT` = 3. The 8-byte line and the small 1 KiB space put line crossings and returns to recently used lines within reach of a short random run, so buffer hits, speculation hits and misses all occur often. The short latency lets a read land while a prefetch is still outstanding, and lets an invalidate catch a prefetch in flight, without long idle stretches. The bench reaches the 128-bit default only through the offset width, so that width is exercised by the parameterized extraction.

// File: rtl/fa_pkg.sv
package fa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_PF,
        ST_FILL,
        ST_RESP
    } fa_state_t;

    function automatic logic bad_align(input xfer_size_t sz, input logic [1:0] lo);
        bad_align = (sz == SZ_BAD) ||
                    (sz == SZ_HALF && lo[0]) ||
                    (sz == SZ_WORD && (lo != 2'b00));
    endfunction

endpackage

// File: rtl/fa_extract.sv
module fa_extract
    import fa_pkg::*;
#(
    parameter int LINE_W = 128,
    parameter int OFF_W  = 4
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  off,
    input  xfer_size_t        size,
    output logic [31:0]       data
);
    logic [LINE_W-1:0] shifted;

    // Lowest-addressed byte lands in bits 7:0 (little-endian lanes)
    assign shifted = line >> {off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: data = {24'd0, shifted[7:0]};
            SZ_HALF: data = {16'd0, shifted[15:0]};
            SZ_WORD: data = shifted[31:0];
            default: data = 32'd0;
        endcase
    end
endmodule

// File: rtl/fa_buf.sv
module fa_buf #(
    parameter int TAG_W  = 6,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              drop,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [LINE_W-1:0] load_line,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] line
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (drop) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            tag  <= load_tag;
            line <= load_line;
        end
    end
endmodule

// File: rtl/flash_accel.sv
module flash_accel
    import fa_pkg::*;
#(
    parameter int LINE_W    = 128,
    parameter int ADDR_W    = 20,
    parameter int ARRAY_LAT = 4,
    localparam int OFF_W    = $clog2(LINE_W / 8),
    localparam int TAG_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ready,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              mem_req,
    output logic [TAG_W-1:0]  mem_line_addr,
    input  logic              mem_valid,
    input  logic [LINE_W-1:0] mem_rdata
);
    // ARRAY_LAT documents the array timing; the controller waits on mem_valid.
    localparam int LAT_CHECK = ARRAY_LAT;

    fa_state_t st_q, st_d;

    xfer_size_t       size_in;
    logic [TAG_W-1:0] tag_in;
    logic [OFF_W-1:0] off_in;
    logic             reject;

    // Captured request
    logic [TAG_W-1:0] cap_tag;
    logic [OFF_W-1:0] cap_off;
    xfer_size_t       cap_size;

    // Buffers
    logic              lb_v, sb_v;
    logic [TAG_W-1:0]  lb_tag, sb_tag;
    logic [LINE_W-1:0] lb_line, sb_line;
    logic              lb_hit, sb_hit;
    logic              lb_load;
    logic [TAG_W-1:0]  lb_ltag;
    logic [LINE_W-1:0] lb_lline;
    logic              sb_load;

    // Array tracker
    logic             arr_busy, arr_pf, pf_kill;
    logic             issue_dem, issue_pf;
    logic [TAG_W-1:0] issue_tag;

    // Response
    logic [31:0]       rd_d, rd_q;
    logic              err_d, err_q;
    logic              promote;
    logic [LINE_W-1:0] ext_line;
    logic [OFF_W-1:0]  ext_off;
    xfer_size_t        ext_size;
    logic [31:0]       ext_data;

    assign size_in = xfer_size_t'(bus_size);
    assign tag_in  = bus_addr[ADDR_W-1:OFF_W];
    assign off_in  = bus_addr[OFF_W-1:0];
    assign reject  = bus_write || bad_align(size_in, bus_addr[1:0]);
    assign lb_hit  = lb_v && (lb_tag == tag_in);
    assign sb_hit  = sb_v && (sb_tag == tag_in);

    // ---------------- line buffer and speculation buffer ----------------
    fa_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_lb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (invalidate),
        .load     (lb_load),
        .drop     (1'b0),
        .load_tag (lb_ltag),
        .load_line(lb_lline),
        .valid    (lb_v),
        .tag      (lb_tag),
        .line     (lb_line)
    );

    assign sb_load = mem_valid && arr_busy && arr_pf && !pf_kill && !invalidate;

    fa_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (invalidate),
        .load     (sb_load),
        .drop     (issue_pf),
        .load_tag (mem_line_addr),
        .load_line(mem_rdata),
        .valid    (sb_v),
        .tag      (sb_tag),
        .line     (sb_line)
    );

    // ---------------- lane extraction (one shared instance) ----------------
    always_comb begin
        if (st_q == ST_FILL) begin
            ext_line = mem_rdata;
            ext_off  = cap_off;
            ext_size = cap_size;
        end else begin
            ext_line = lb_hit ? lb_line : sb_line;
            ext_off  = off_in;
            ext_size = size_in;
        end
    end

    fa_extract #(.LINE_W(LINE_W), .OFF_W(OFF_W)) u_ext (
        .line(ext_line),
        .off (ext_off),
        .size(ext_size),
        .data(ext_data)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- next state and control ----------------
    always_comb begin
        st_d      = st_q;
        issue_dem = 1'b0;
        issue_pf  = 1'b0;
        issue_tag = cap_tag;
        promote   = 1'b0;
        lb_load   = 1'b0;
        lb_ltag   = cap_tag;
        lb_lline  = mem_rdata;
        rd_d      = rd_q;
        err_d     = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (bus_req) begin
                    if (reject) begin
                        rd_d  = 32'd0;
                        err_d = 1'b1;
                        st_d  = ST_RESP;
                    end else if (lb_hit) begin
                        rd_d  = ext_data;
                        err_d = 1'b0;
                        st_d  = ST_RESP;
                    end else if (sb_hit) begin
                        rd_d      = ext_data;
                        err_d     = 1'b0;
                        promote   = 1'b1;
                        lb_load   = 1'b1;
                        lb_ltag   = sb_tag;
                        lb_lline  = sb_line;
                        issue_pf  = !arr_busy;
                        issue_tag = sb_tag + TAG_W'(1);
                        st_d      = ST_RESP;
                    end else if (arr_busy) begin
                        st_d = ST_WAIT_PF;
                    end else begin
                        issue_dem = 1'b1;
                        issue_tag = tag_in;
                        st_d      = ST_FILL;
                    end
                end
            end
            ST_WAIT_PF: begin
                if (!arr_busy) begin
                    issue_dem = 1'b1;
                    issue_tag = cap_tag;
                    st_d      = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    lb_load   = 1'b1;
                    rd_d      = ext_data;
                    err_d     = 1'b0;
                    issue_pf  = 1'b1;
                    issue_tag = cap_tag + TAG_W'(1);
                    st_d      = ST_RESP;
                end
            end
            ST_RESP: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- registered outputs and tracking ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q          <= 32'd0;
            err_q         <= 1'b0;
            mem_req       <= 1'b0;
            mem_line_addr <= '0;
            arr_busy      <= 1'b0;
            arr_pf        <= 1'b0;
            pf_kill       <= 1'b0;
            cap_tag       <= '0;
            cap_off       <= '0;
            cap_size      <= SZ_BYTE;
        end else begin
            rd_q    <= rd_d;
            err_q   <= err_d;
            mem_req <= issue_dem || issue_pf;
            if (issue_dem || issue_pf) begin
                mem_line_addr <= issue_tag;
                arr_busy      <= 1'b1;
                arr_pf        <= issue_pf;
                pf_kill       <= invalidate;
            end else begin
                if (mem_valid) arr_busy <= 1'b0;
                if (invalidate && arr_busy) pf_kill <= 1'b1;
            end
            if (st_q == ST_IDLE && bus_req) begin
                cap_tag  <= tag_in;
                cap_off  <= off_in;
                cap_size <= size_in;
            end
        end
    end

    assign bus_ready = (st_q == ST_RESP);
    assign bus_err   = bus_ready && err_q;
    assign bus_rdata = bus_ready ? rd_q : 32'd0;

    // ---------------- assertions ----------------
    initial begin
        AST_LAT_POSITIVE: assert (LAT_CHECK >= 1); // R6
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready); // R11

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_dem || issue_pf) |-> (!arr_busy || mem_valid)); // R11

    AST_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bus_req && bus_write) |=> (bus_ready && bus_err && !mem_req)); // R4

    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bus_req && size_in == SZ_WORD && bus_addr[1:0] != 2'b00)
        |=> (bus_ready && bus_err)); // R3

    AST_LB_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bus_req && !reject && lb_hit) |=> (bus_ready && !bus_err && !mem_req)); // R5

    AST_PF_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && mem_valid) |=> (mem_req && mem_line_addr == $past(cap_tag) + TAG_W'(1))); // R7

    AST_BUFS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_v && sb_v) |-> (lb_tag != sb_tag)); // R8

    AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> (!lb_v && !sb_v)); // R10

    AST_PROMOTE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        promote |-> (sb_v && !lb_hit)); // R8

endmodule

// File: tb/sim_flash_accel.sv
`timescale 1ns/1ps
module sim_flash_accel;
    localparam int LW  = 64;
    localparam int AW  = 10;
    localparam int LAT = 3;
    localparam int OW  = $clog2(LW / 8);
    localparam int TW  = AW - OW;
    localparam int NB  = LW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic invalidate = 1'b0;
    logic bus_req = 1'b0;
    logic bus_write = 1'b0;
    logic [1:0] bus_size = 2'd0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_ready, bus_err;
    logic [31:0] bus_rdata;
    logic mem_req;
    logic [TW-1:0] mem_line_addr;
    logic mem_valid;
    logic [LW-1:0] mem_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flash_accel #(.LINE_W(LW), .ADDR_W(AW), .ARRAY_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .invalidate(invalidate),
        .bus_req(bus_req), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_line_addr(mem_line_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata)
    );

    // ---------------- array model ----------------
    function automatic logic [7:0] byte_val(input int a);
        byte_val = 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [LW-1:0] line_of(input logic [TW-1:0] t);
        logic [LW-1:0] l = '0;
        for (int b = 0; b < NB; b++) l[b*8 +: 8] = byte_val(int'(t) * NB + b);
        return l;
    endfunction

    logic [LAT-1:0] vpipe = '0;
    logic [TW-1:0]  apipe [LAT];
    int req_cnt = 0;
    logic [TW-1:0] last_req = '0;
    int dbl_ready = 0;
    logic prev_ready = 1'b0;

    always @(posedge clk) begin
        vpipe <= {vpipe[LAT-2:0], mem_req};
        apipe[0] <= mem_line_addr;
        for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
        if (mem_req) begin
            req_cnt  <= req_cnt + 1;
            last_req <= mem_line_addr;
        end
        if (rst_n && bus_ready && prev_ready) dbl_ready <= dbl_ready + 1;
        prev_ready <= bus_ready;
    end

    assign mem_valid = vpipe[LAT-1];
    assign mem_rdata = line_of(apipe[LAT-1]);

    // ---------------- expected values ----------------
    function automatic logic exp_err(input int a, input int sz, input logic wr);
        return wr || sz == 3 || (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 2'b00);
    endfunction

    function automatic logic [31:0] exp_data(input int a, input int sz);
        logic [31:0] v = '0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int i = 0; i < n; i++) v[i*8 +: 8] = byte_val(a + i);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input int a, input int sz, input logic wr,
                        output logic [31:0] d, output logic e, output int cyc, output int reqs);
        int r0;
        @(negedge clk);
        bus_req = 1'b1; bus_write = wr; bus_size = 2'(sz); bus_addr = AW'(a);
        r0 = req_cnt;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bus_ready && cyc < 1000);
        d = bus_rdata; e = bus_err;
        reqs = req_cnt - r0;
        bus_req = 1'b0; bus_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_inval();
        @(negedge clk); invalidate = 1'b1;
        @(negedge clk); invalidate = 1'b0;
    endtask

    // Full read with data/error check
    task automatic rd_chk(input int a, input int sz, input logic wr, input string req,
                          output int cyc, output int reqs);
        logic [31:0] d; logic e;
        logic ee;
        xfer(a, sz, wr, d, e, cyc, reqs);
        ee = exp_err(a, sz, wr);
        chk(e == ee, {req, " err"}, e, ee);
        chk(d == (ee ? 32'd0 : exp_data(a, sz)), {req, " data"}, d, ee ? 32'd0 : exp_data(a, sz));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int cyc, reqs, r0;
        int seed;
        logic m_lb_v, m_sb_v;
        int m_lb, m_sb;
        seed = 32'h1F2E3D;
        void'($urandom(seed));
        for (int i = 0; i < LAT; i++) apipe[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_ready == 1'b0 && bus_err == 1'b0 && mem_req == 1'b0, "R1 outputs idle in reset",
            {bus_ready, bus_err, mem_req}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(bus_ready == 1'b0 && mem_req == 1'b0, "R1 outputs idle after reset", {bus_ready, mem_req}, 0);

        // R6: cold miss, R2 word data
        rd_chk('h040, 2, 1'b0, "R2 word miss", cyc, reqs);
        chk(cyc == LAT + 2, "R6 miss latency", cyc, LAT + 2);
        chk(reqs == 1, "R6 one demand request", reqs, 1);
        chk(last_req == TW'('h040 / NB), "R6 demand line address", last_req, 'h040 / NB);
        idle(1);
        // R7: prefetch of next line
        chk(last_req == TW'('h040 / NB + 1), "R7 prefetch next line", last_req, 'h040 / NB + 1);

        // R5 / R2: line buffer hits, byte and halfword lanes
        rd_chk('h043, 0, 1'b0, "R2 byte lane", cyc, reqs);
        chk(cyc == 1, "R5 byte hit latency", cyc, 1);
        chk(reqs == 0, "R5 no array request", reqs, 0);
        rd_chk('h046, 1, 1'b0, "R2 halfword lane", cyc, reqs);
        chk(cyc == 1, "R5 half hit latency", cyc, 1);
        idle(LAT + 3);

        // R8: speculation buffer hit, promotion, next prefetch
        r0 = req_cnt;
        rd_chk('h04C, 2, 1'b0, "R8 spec hit data", cyc, reqs);
        chk(cyc == 1, "R8 spec hit latency", cyc, 1);
        idle(1);
        chk(req_cnt == r0 + 1 && last_req == TW'('h04C / NB + 1), "R8 prefetch following line",
            last_req, 'h04C / NB + 1);
        rd_chk('h048, 0, 1'b0, "R8 promoted line", cyc, reqs);
        chk(cyc == 1, "R8 promoted line hits", cyc, 1);
        idle(LAT + 3);

        // R12: 8-byte lines, only one line kept -> old line misses
        rd_chk('h047, 0, 1'b0, "R12 boundary byte", cyc, reqs);
        chk(cyc == LAT + 2, "R12 previous line now a miss", cyc, LAT + 2);
        idle(LAT + 3);

        // R4: write rejected, buffered line intact
        rd_chk('h044, 2, 1'b1, "R4 write", cyc, reqs);
        chk(cyc == 1 && reqs == 0, "R4 write one cycle no request", {cyc, reqs}, 1);
        rd_chk('h044, 2, 1'b0, "R4 read after write", cyc, reqs);
        chk(cyc == 1, "R4 buffered line still hits", cyc, 1);

        // R3: misaligned and bad size
        rd_chk('h041, 1, 1'b0, "R3 odd halfword", cyc, reqs);
        chk(cyc == 1, "R3 odd halfword timing", cyc, 1);
        rd_chk('h042, 2, 1'b0, "R3 unaligned word", cyc, reqs);
        rd_chk('h040, 3, 1'b0, "R3 size code 3", cyc, reqs);
        idle(LAT + 3);

        // R10: invalidate empties buffers
        pulse_inval();
        rd_chk('h044, 2, 1'b0, "R10 read after invalidate", cyc, reqs);
        chk(cyc == LAT + 2, "R10 line buffer cleared", cyc, LAT + 2);
        // in-flight prefetch of next line killed
        pulse_inval();
        idle(LAT + 3);
        rd_chk('h048, 2, 1'b0, "R10 killed prefetch data", cyc, reqs);
        chk(cyc == LAT + 2, "R10 killed prefetch discarded", cyc, LAT + 2);
        idle(LAT + 3);

        // R9: miss while prefetch outstanding
        rd_chk('h100, 2, 1'b0, "R9 first miss", cyc, reqs);
        rd_chk('h200, 2, 1'b0, "R9 miss behind prefetch", cyc, reqs);
        chk(cyc > LAT + 2, "R9 waits for prefetch", cyc, LAT + 3);
        chk(reqs == 1 && last_req == TW'('h200 / NB), "R9 demand issued after prefetch", last_req, 'h200 / NB);
        idle(LAT + 3);

        // Random phase with buffer model (R2 R5 R6 R8 R3 R4)
        pulse_inval();
        idle(LAT + 3);
        m_lb_v = 1'b0; m_sb_v = 1'b0; m_lb = 0; m_sb = 0;
        for (int k = 0; k < 400; k++) begin
            int a, sz, t, expc;
            logic wr;
            a  = int'($urandom_range(0, 'h7F));
            sz = int'($urandom_range(0, 9));
            sz = (sz < 3) ? 0 : (sz < 6) ? 1 : (sz < 9) ? 2 : 3;
            if ($urandom_range(0, 9) < 7) begin
                if (sz == 1) a = a & ~1;
                if (sz == 2) a = a & ~3;
            end
            wr = ($urandom_range(0, 9) == 0);
            t = a / NB;
            if (exp_err(a, sz, wr))           expc = 1;
            else if (m_lb_v && m_lb == t)     expc = 1;
            else if (m_sb_v && m_sb == t) begin
                expc = 1; m_lb = t; m_lb_v = 1'b1; m_sb = (t + 1) % (1 << TW);
            end else begin
                expc = LAT + 2; m_lb = t; m_lb_v = 1'b1; m_sb = (t + 1) % (1 << TW); m_sb_v = 1'b1;
            end
            rd_chk(a, sz, wr, "R2 random", cyc, reqs);
            chk(cyc == expc, "R5/R6/R8 random latency", cyc, expc);
            idle(LAT + 4);
            if ($urandom_range(0, 29) == 0) begin
                pulse_inval();
                idle(LAT + 3);
                m_lb_v = 1'b0; m_sb_v = 1'b0;
            end
        end

        // R11: ready never held two cycles
        chk(dbl_ready == 0, "R11 ready single pulse", dbl_ready, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule